// File: doc/BRIEF.md
# 8-bit I/O bus slave with byte-wise capture window

This block is the host-side port of a position and speed capture unit. It sits on an 8-bit ISA-style I/O bus and answers only those cycles whose 10-bit address falls inside a 16-byte window. The window's upper six address bits come from an external jumper input. The bus inputs are brought into the block clock domain through two-flop synchronisers. A four-state machine then walks from idle, through an address/data capture state, into either a read state or a write state. It holds there until the host releases the active strobe.

Reads return one byte of four 32-bit values that the capture unit presents. Writes do not store into those values. A write to one of three command offsets produces a single-cycle strobe toward the capture unit. A write to one of four preset offsets fills one byte of a 32-bit preset word, which the capture unit loads on its load strobe. The data bus is modelled as separate input, output and output-enable signals, so the pad driver stays outside the block.

Top module: `io8_slave`

## Requirements
- R1: After reset the output enable is low, all three strobes are low and the preset word is zero.
- R2: An access is taken only when the address-enable input is low and address bits 9:4 equal the jumper value. Any other cycle raises no output enable, fires no strobe and leaves the preset word unchanged.
- R3: During a selected read at offset k (0 to 15), the data output carries bits 8*(k mod 4)+7 down to 8*(k mod 4) of capture word k div 4. Byte 0 of each word is its least significant byte.
- R4: The output enable is high only while the read strobe, as seen through the two-flop synchroniser, is low in the read state. It falls once the strobe is released.
- R5: A selected write at offset 0 fires the sample strobe, offset 1 fires the clear strobe, and offset 2 fires the load strobe. Each fires exactly once per write cycle, however long the write strobe is held.
- R6: Each strobe is one clock wide, and no two strobes are high in the same cycle.
- R7: A selected write at offset 4, 5, 6 or 7 puts the written byte into preset bits 7:0, 15:8, 23:16 or 31:24 respectively. Writes to offsets 3 and 8 to 15 change neither the preset word nor the strobes.
- R8: If both read and write strobes are active when the access is decoded, the read is served and no strobe fires.
- R9: When a read strobe is released at the same instant a write strobe is asserted at a new offset inside the window, the read completes and the write is then taken as a separate access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 10 | Bus I/O address |
| bus_data_i | input | 8 | Data bus, host-to-slave direction |
| bus_data_o | output | 8 | Data bus, slave-to-host direction |
| bus_data_oe_o | output | 1 | Drive enable for the data bus pads |
| bus_aen_i | input | 1 | Address enable; low selects a plain I/O cycle |
| bus_rd_n_i | input | 1 | I/O read strobe, active low |
| bus_wr_n_i | input | 1 | I/O write strobe, active low |
| base_sel_i | input | 6 | Jumper value compared with address bits 9:4 |
| cap_word_i | input | 4x32 | Four capture values presented by the capture unit |
| sample_pulse_o | output | 1 | One-cycle sample command |
| clear_pulse_o | output | 1 | One-cycle clear-position command |
| load_pulse_o | output | 1 | One-cycle load-preset command |
| preset_val_o | output | 32 | Preset word assembled from byte writes |

## Verification
The end of one bus access and the start of the next can land in the same clock cycle. While the machine leaves the read state, the same synchronised sample already shows a new address and an active write strobe. The bench provokes this by releasing the read strobe on the same edge that it presents a new in-window offset with the write strobe low. The read byte is judged before the release. After the release, the bench judges that exactly one strobe of the expected kind appears and that the output enable has fallen.

// File: rtl/io8_pkg.sv
package io8_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_CAPT  = 2'd1,
        BUS_READ  = 2'd2,
        BUS_WRITE = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic sample;
        logic clear;
        logic load;
    } strobe_t;

endpackage

// File: rtl/io8_sync.sv
module io8_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/io8_fsm.sv
module io8_fsm
    import io8_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 8,
    localparam int BASE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aen_s,
    input  logic              rd_n_s,
    input  logic              wr_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [BASE_W-1:0] base_i,
    output bus_state_e        state_o,
    output logic [OFF_W-1:0]  off_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              fire_o,
    output logic              rd_active_o
);

    typedef struct packed {
        bus_state_e        state;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
        logic              fire;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      hit;

    always_comb begin
        hit = !aen_s && (addr_s[ADDR_W-1:OFF_W] == base_i);
        r_d = r_q;
        r_d.fire = 1'b0;
        unique case (r_q.state)
            BUS_IDLE: begin
                if (hit) r_d.state = BUS_CAPT;
            end
            BUS_CAPT: begin
                r_d.off  = addr_s[OFF_W-1:0];
                r_d.data = data_s;
                if (!rd_n_s) begin
                    r_d.state = BUS_READ;
                end else if (!wr_n_s) begin
                    r_d.state = BUS_WRITE;
                    r_d.fire  = 1'b1;
                end else if (!hit) begin
                    r_d.state = BUS_IDLE;
                end
            end
            BUS_READ: begin
                if (rd_n_s) r_d.state = BUS_IDLE;
            end
            BUS_WRITE: begin
                if (wr_n_s) r_d.state = BUS_IDLE;
            end
            default: r_d.state = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: BUS_IDLE, off: '0, data: '0, fire: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o     = r_q.state;
    assign off_o       = r_q.off;
    assign wdata_o     = r_q.data;
    assign fire_o      = r_q.fire;
    assign rd_active_o = (r_q.state == BUS_READ) && !rd_n_s;

endmodule

// File: rtl/io8_wr_decode.sv
module io8_wr_decode
    import io8_pkg::*;
#(
    parameter int OFF_W      = 4,
    parameter int DATA_W     = 8,
    parameter int WORD_W     = 32,
    parameter int SAMPLE_OFF = 0,
    parameter int CLEAR_OFF  = 1,
    parameter int LOAD_OFF   = 2,
    parameter int PRESET_OFF = 4,
    localparam int BYTES     = WORD_W / DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] data_i,
    output strobe_t           strobe_o,
    output logic [WORD_W-1:0] preset_o
);

    typedef struct packed {
        strobe_t           strobe;
        logic [WORD_W-1:0] preset;
    } wr_regs_t;

    wr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.strobe.sample = fire_i && (off_i == OFF_W'(SAMPLE_OFF));
        r_d.strobe.clear  = fire_i && (off_i == OFF_W'(CLEAR_OFF));
        r_d.strobe.load   = fire_i && (off_i == OFF_W'(LOAD_OFF));
        for (int b = 0; b < BYTES; b++) begin
            if (fire_i && (off_i == OFF_W'(PRESET_OFF + b))) begin
                r_d.preset[b*DATA_W +: DATA_W] = data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign strobe_o = r_q.strobe;
    assign preset_o = r_q.preset;

endmodule

// File: rtl/io8_rd_mux.sv
module io8_rd_mux #(
    parameter int OFF_W   = 4,
    parameter int DATA_W  = 8,
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 4,
    localparam int BYTES  = WORD_W / DATA_W,
    localparam int BSEL_W = $clog2(BYTES)
) (
    input  logic [N_WORDS-1:0][WORD_W-1:0] word_i,
    input  logic [OFF_W-1:0]               off_i,
    input  logic                           oe_i,
    output logic [DATA_W-1:0]              data_o
);

    logic [WORD_W-1:0] word_sel;

    always_comb begin
        word_sel = word_i[off_i[OFF_W-1:BSEL_W]];
        data_o   = oe_i ? word_sel[off_i[BSEL_W-1:0]*DATA_W +: DATA_W] : '0;
    end

endmodule

// File: rtl/io8_slave.sv
module io8_slave
    import io8_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int WORD_W      = 32,
    parameter int N_WORDS     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int OFF_W      = $clog2(N_WORDS * (WORD_W / DATA_W)),
    localparam int BASE_W     = ADDR_W - OFF_W,
    localparam int SYNC_W     = 3 + ADDR_W + DATA_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr_i,
    input  logic [DATA_W-1:0]              bus_data_i,
    output logic [DATA_W-1:0]              bus_data_o,
    output logic                           bus_data_oe_o,
    input  logic                           bus_aen_i,
    input  logic                           bus_rd_n_i,
    input  logic                           bus_wr_n_i,
    input  logic [BASE_W-1:0]              base_sel_i,
    input  logic [N_WORDS-1:0][WORD_W-1:0] cap_word_i,
    output logic                           sample_pulse_o,
    output logic                           clear_pulse_o,
    output logic                           load_pulse_o,
    output logic [WORD_W-1:0]              preset_val_o
);

    logic              aen_s, rd_n_s, wr_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    bus_state_e        fsm_state;
    logic [OFF_W-1:0]  acc_off;
    logic [DATA_W-1:0] acc_data;
    logic              acc_fire;
    logic              rd_active;
    strobe_t           strobes;

    io8_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({3'b111, {(ADDR_W + DATA_W){1'b0}}})
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_aen_i, bus_rd_n_i, bus_wr_n_i, bus_addr_i, bus_data_i}),
        .sync_o  ({aen_s, rd_n_s, wr_n_s, addr_s, data_s})
    );

    io8_fsm #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .aen_s       (aen_s),
        .rd_n_s      (rd_n_s),
        .wr_n_s      (wr_n_s),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .base_i      (base_sel_i),
        .state_o     (fsm_state),
        .off_o       (acc_off),
        .wdata_o     (acc_data),
        .fire_o      (acc_fire),
        .rd_active_o (rd_active)
    );

    io8_wr_decode #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W),
        .WORD_W (WORD_W)
    ) wr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (acc_fire),
        .off_i    (acc_off),
        .data_i   (acc_data),
        .strobe_o (strobes),
        .preset_o (preset_val_o)
    );

    io8_rd_mux #(
        .OFF_W   (OFF_W),
        .DATA_W  (DATA_W),
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS)
    ) rd_i (
        .word_i (cap_word_i),
        .off_i  (acc_off),
        .oe_i   (rd_active),
        .data_o (bus_data_o)
    );

    assign bus_data_oe_o  = rd_active;
    assign sample_pulse_o = strobes.sample;
    assign clear_pulse_o  = strobes.clear;
    assign load_pulse_o   = strobes.load;

endmodule

// File: rtl/io8_slave_chk.sv
module io8_slave_chk
    import io8_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd_n_i,
    input logic        bus_data_oe_o,
    input logic        sample_pulse_o,
    input logic        clear_pulse_o,
    input logic        load_pulse_o,
    input logic [31:0] preset_val_o,
    input bus_state_e  fsm_state
);

    // R4: a driven bus implies the raw read strobe was low two edges earlier
    p_oe_needs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe_o |-> !$past(bus_rd_n_i, 2));

    // R6: strobes never overlap
    p_strobes_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_pulse_o, clear_pulse_o, load_pulse_o}));

    // R6: every strobe is one cycle wide
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pulse_o || clear_pulse_o || load_pulse_o) |=>
        !(sample_pulse_o || clear_pulse_o || load_pulse_o));

    // R5: a strobe follows a cycle spent in the write state
    p_strobe_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_pulse_o || clear_pulse_o || load_pulse_o) |->
        $past(fsm_state == BUS_WRITE));

    // R7: the preset word moves only after a write-state cycle
    p_preset_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(preset_val_o) |-> $past(fsm_state == BUS_WRITE));

endmodule

bind io8_slave io8_slave_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_rd_n_i     (bus_rd_n_i),
    .bus_data_oe_o  (bus_data_oe_o),
    .sample_pulse_o (sample_pulse_o),
    .clear_pulse_o  (clear_pulse_o),
    .load_pulse_o   (load_pulse_o),
    .preset_val_o   (preset_val_o),
    .fsm_state      (fsm_state)
);

// File: tb/io8_slave_tb_top.sv
module io8_slave_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [9:0]        addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              oe;
    logic              aen = 1'b1;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [5:0]        base = 6'h2C;
    logic [3:0][31:0]  cap = '0;
    logic              p_smp, p_clr, p_ld;
    logic [31:0]       preset;

    int checks = 0;
    int fails  = 0;
    int n_smp = 0, n_clr = 0, n_ld = 0, n_wide = 0;
    logic prev_any = 1'b0;
    logic [31:0] exp_preset = '0;
    int exp_smp = 0, exp_clr = 0, exp_ld = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    io8_slave dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr_i     (addr),
        .bus_data_i     (din),
        .bus_data_o     (dout),
        .bus_data_oe_o  (oe),
        .bus_aen_i      (aen),
        .bus_rd_n_i     (rd_n),
        .bus_wr_n_i     (wr_n),
        .base_sel_i     (base),
        .cap_word_i     (cap),
        .sample_pulse_o (p_smp),
        .clear_pulse_o  (p_clr),
        .load_pulse_o   (p_ld),
        .preset_val_o   (preset)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_smp) n_smp++;
            if (p_clr) n_clr++;
            if (p_ld)  n_ld++;
            if (prev_any && (p_smp || p_clr || p_ld)) n_wide++;
            if ((32'(p_smp) + 32'(p_clr) + 32'(p_ld)) > 1) n_wide++;
            prev_any = p_smp || p_clr || p_ld;
        end
    end

    function automatic logic [7:0] exp_byte(input logic [3:0][31:0] w, input logic [3:0] k);
        logic [31:0] sel = w[k / 4];
        return sel[(k % 4) * 8 +: 8];
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // models the expected effect of a write at the ports
    task automatic model_write(input bit sel, input logic [3:0] k, input logic [7:0] d);
        if (sel) begin
            case (k)
                4'd0: exp_smp++;
                4'd1: exp_clr++;
                4'd2: exp_ld++;
                4'd4, 4'd5, 4'd6, 4'd7: exp_preset[(k - 4) * 8 +: 8] = d;
                default: ;
            endcase
        end
    endtask

    task automatic check_side(input string tag);
        check(n_smp == exp_smp, {tag, " sample count"}, n_smp, exp_smp);
        check(n_clr == exp_clr, {tag, " clear count"}, n_clr, exp_clr);
        check(n_ld == exp_ld, {tag, " load count"}, n_ld, exp_ld);
        check(preset == exp_preset, {tag, " preset"}, preset, exp_preset);
    endtask

    task automatic do_read(input logic [5:0] hi, input logic [3:0] k, input logic a,
                           output logic [7:0] d, output logic oe_mid, output logic oe_end);
        addr = {hi, k}; aen = a; din = 8'($urandom);
        idle(2);
        rd_n = 1'b0;
        idle(6);
        d = dout; oe_mid = oe;
        rd_n = 1'b1;
        idle(4);
        oe_end = oe;
        aen = 1'b1; addr = 10'($urandom);
        idle(4);
    endtask

    task automatic do_write(input logic [5:0] hi, input logic [3:0] k, input logic a,
                            input logic [7:0] d, input int hold);
        addr = {hi, k}; aen = a; din = d;
        idle(2);
        wr_n = 1'b0;
        idle(hold);
        wr_n = 1'b1;
        idle(4);
        aen = 1'b1; addr = 10'($urandom);
        idle(4);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic om, oend;
        void'($urandom(32'd4711));
        for (int w = 0; w < 4; w++) cap[w] = $urandom;
        idle(3);
        check(oe == 1'b0, "R1 oe at reset", oe, 0);
        check(preset == '0, "R1 preset at reset", preset, 0);
        check(!(p_smp || p_clr || p_ld), "R1 strobes at reset", {p_smp, p_clr, p_ld}, 0);
        rst_n = 1'b1;
        idle(4);
        check(oe == 1'b0 && preset == '0, "R1 after release", oe, 0);

        // R3: every offset once, directed
        for (int k = 0; k < 16; k++) begin
            do_read(base, 4'(k), 1'b0, d, om, oend);
            check(om == 1'b1, "R3 oe during read", om, 1);
            check(d == exp_byte(cap, 4'(k)), "R3 read byte", d, exp_byte(cap, 4'(k)));
            check(oend == 1'b0, "R4 oe after release", oend, 0);
        end

        // R2: wrong base and AEN high
        do_read(base ^ 6'h01, 4'd3, 1'b0, d, om, oend);
        check(om == 1'b0, "R2 wrong base read", om, 0);
        do_read(base, 4'd3, 1'b1, d, om, oend);
        check(om == 1'b0, "R2 aen high read", om, 0);
        do_write(base ^ 6'h20, 4'd0, 1'b0, 8'hAA, 4);
        do_write(base, 4'd4, 1'b1, 8'h5A, 4);
        check_side("R2 unselected writes");

        // R5: strobes with short and long holds
        do_write(base, 4'd0, 1'b0, 8'h00, 1); model_write(1, 4'd0, 8'h00);
        do_write(base, 4'd1, 1'b0, 8'h00, 12); model_write(1, 4'd1, 8'h00);
        do_write(base, 4'd2, 1'b0, 8'h00, 5); model_write(1, 4'd2, 8'h00);
        check_side("R5 command offsets");
        check(n_wide == 0, "R6 strobe width", n_wide, 0);

        // R7: preset bytes and ignored offsets
        for (int b = 0; b < 4; b++) begin
            d = 8'(8'h11 * (b + 1));
            do_write(base, 4'(4 + b), 1'b0, d, 3); model_write(1, 4'(4 + b), d);
        end
        check(preset == 32'h44332211, "R7 preset assembled", preset, 32'h44332211);
        do_write(base, 4'd3, 1'b0, 8'hEE, 3);
        do_write(base, 4'd9, 1'b0, 8'hEE, 3);
        do_write(base, 4'd15, 1'b0, 8'hEE, 3);
        check_side("R7 ignored offsets");

        // R8: both strobes active at decode
        addr = {base, 4'd6}; aen = 1'b0;
        idle(2);
        rd_n = 1'b0; wr_n = 1'b0;
        idle(6);
        check(oe == 1'b1 && dout == exp_byte(cap, 4'd6), "R8 read wins", dout, exp_byte(cap, 4'd6));
        rd_n = 1'b1; wr_n = 1'b1;
        idle(2);
        aen = 1'b1;
        idle(6);
        check_side("R8 no strobe");

        // R9: read release and new write in the same instant
        addr = {base, 4'd13}; aen = 1'b0;
        idle(2);
        rd_n = 1'b0;
        idle(6);
        check(oe == 1'b1 && dout == exp_byte(cap, 4'd13), "R9 first read", dout, exp_byte(cap, 4'd13));
        rd_n = 1'b1; wr_n = 1'b0; addr = {base, 4'd0};
        model_write(1, 4'd0, 8'h00);
        idle(5);
        check(oe == 1'b0, "R9 oe dropped", oe, 0);
        wr_n = 1'b1;
        idle(4);
        aen = 1'b1;
        idle(4);
        check_side("R9 write after read");

        // random mix
        for (int i = 0; i < 150; i++) begin
            int kind = int'($urandom % 4);
            logic [3:0] k = 4'($urandom);
            logic [7:0] wd = 8'($urandom);
            for (int w = 0; w < 4; w++) cap[w] = $urandom;
            if (kind == 0) begin
                do_read(base, k, 1'b0, d, om, oend);
                check(om && d == exp_byte(cap, k), "R3 random read", d, exp_byte(cap, k));
            end else if (kind == 1) begin
                do_read(base + 6'(1 + $urandom % 63), k, 1'b0, d, om, oend);
                check(om == 1'b0, "R2 random miss", om, 0);
            end else begin
                bit hitw = (kind == 2);
                do_write(hitw ? base : ~base, k, 1'b0, wd, 1 + int'($urandom % 6));
                model_write(hitw, k, wd);
                check_side(hitw ? "R5 R7 random write" : "R2 random write miss");
            end
        end
        check(n_wide == 0, "R6 strobe width final", n_wide, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule